// File: doc/BRIEF.md
# Two-Way Write-Back Byte Cache

This block is a data cache that sits between a processor and a byte-addressed memory with 24-bit addresses. It has 256 lines of 16 bytes each, arranged as 128 sets of two ways. Each line has its own tag, valid bit and dirty bit. The processor issues one single-byte read or write at a time through a valid/ready handshake. The cache answers a hit from its own storage. On a miss it moves whole 16-byte lines over a memory port that has separate request/acknowledge pairs for fetching a line and for writing one back.

Stores stay in the cache and mark the line dirty. Memory sees the new data only when that line is evicted. A store that misses first fetches the line and then merges its byte.

The victim policy uses three rules in order. An empty way is taken first. If both ways are valid, a clean way is taken, so no write-back is needed. If both ways are clean or both are dirty, one least-recently-used bit per set chooses. That bit is updated on every hit and every fill.

Top module: `wb2way_cache`

## Requirements
- R1: After reset every line is invalid, `cpuReady` is 1, and both memory requests are 0. The first access to any address therefore fetches a line.
- R2: The address is split into a tag (bits 23:11), a set index (bits 10:4) and a byte offset (bits 3:0). A fetch request carries the 20-bit line address `cpuAddr[23:4]`. Byte k of a line travels on bits `8k+7:8k` of the line buses. Each memory request stays high, with a stable address, until its acknowledge arrives.
- R3: A read that hits returns the stored byte on `cpuRdata`, with a one-cycle `cpuRespValid` pulse, two clocks after the accepting edge. A hit makes no memory request.
- R4: A write that hits changes only the cached byte and sets the line dirty. No memory request is issued. A later read returns the new byte.
- R5: On a miss, a way whose valid bit is 0 is filled. The valid line in the other way stays resident.
- R6: On a miss with both ways valid and only one of them dirty, the clean way is replaced without a write-back, even when the dirty way is the least recently used.
- R7: On a miss with both ways dirty, the least recently used way is the victim. Its 16 bytes are written back to its own line address, `{tag, set}`, and only after that write is acknowledged is the new line requested.
- R8: On a miss with both ways valid and clean, the least recently used way is replaced. Both hits and fills count as uses.
- R9: A write miss fetches the line, then merges the byte and leaves the line dirty. The merged byte reaches memory when that line is later evicted.
- R10: `cpuReady` drops on the cycle after a request is accepted. It stays low until the access completes, whether that access hit or needed a write-back and fetch. Only one request is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuValid | input | 1 | Processor request present |
| cpuReady | output | 1 | Cache can accept a request |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 24 | Byte address |
| cpuWdata | input | 8 | Store byte |
| cpuRespValid | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 8 | Loaded byte (for a store, the byte written) |
| memRdReq | output | 1 | Line fetch request |
| memRdAddr | output | 20 | Line address to fetch |
| memRdAck | input | 1 | Fetch done; line data valid this cycle |
| memRdData | input | 128 | Fetched line |
| memWrReq | output | 1 | Line write-back request |
| memWrAddr | output | 20 | Line address being written back |
| memWrData | output | 128 | Line being written back |
| memWrAck | input | 1 | Write-back accepted |

## Verification
The hardest states to reach from the ports are the victim choices made when both ways of a set are already valid. Reaching them means building up a chosen mix of clean and dirty lines and a chosen recency order in one set. The stimulus does this with scripted sequences on a few sets: fills, then hits that reorder recency, then stores that dirty particular ways. Only after that does it issue the conflicting miss. The bench watches the memory port to see whether a write-back happened, its line address and data, and its order against the fetch. Follow-up reads then show which line stayed resident, judged by whether a fetch occurs.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_REFILL
  } ctrlState_t;

  typedef struct packed {
    logic latchReq;
    logic latchVictim;
    logic hitUpdate;
    logic fill;
  } ctrlStrobes_t;

endpackage

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cpuValid,
  input  logic         hit,
  input  logic         victimDirty,
  input  logic         memWrAck,
  input  logic         memRdAck,
  output ctrlStrobes_t strobes,
  output logic         cpuReady,
  output logic         memRdReq,
  output logic         memWrReq
);

  ctrlState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    cpuReady  = 1'b0;
    memRdReq  = 1'b0;
    memWrReq  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReady = 1'b1;
        if (cpuValid) begin
          strobes.latchReq = 1'b1;
          nextState        = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          strobes.hitUpdate = 1'b1;
          nextState         = ST_IDLE;
        end else begin
          strobes.latchVictim = 1'b1;
          nextState           = victimDirty ? ST_WBACK : ST_REFILL;
        end
      end
      ST_WBACK: begin
        memWrReq = 1'b1;
        if (memWrAck) nextState = ST_REFILL;
      end
      ST_REFILL: begin
        memRdReq = 1'b1;
        if (memRdAck) begin
          strobes.fill = 1'b1;
          nextState    = ST_LOOKUP;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 4,
  parameter int SET_W  = 7,
  localparam int TAG_W   = ADDR_W - SET_W - OFF_W,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = 8 * (1 << OFF_W),
  localparam int SETS    = 1 << SET_W
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic               cpuWrite,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [7:0]         cpuWdata,
  input  logic [LINE_W-1:0]  memRdData,
  output logic               hit,
  output logic               victimDirty,
  output logic               cpuRespValid,
  output logic [7:0]         cpuRdata,
  output logic [LADDR_W-1:0] memRdAddr,
  output logic [LADDR_W-1:0] memWrAddr,
  output logic [LINE_W-1:0]  memWrData
);

  localparam int NWAYS = 2;

  logic [ADDR_W-1:0] reqAddr;
  logic              reqWrite;
  logic [7:0]        reqWdata;
  logic [TAG_W-1:0]  reqTag;
  logic [SET_W-1:0]  reqSet;
  logic [OFF_W-1:0]  reqOff;

  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqSet = reqAddr[OFF_W +: SET_W];
  assign reqOff = reqAddr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (strobes.latchReq) begin
      reqAddr  <= cpuAddr;
      reqWrite <= cpuWrite;
      reqWdata <= cpuWdata;
    end
  end

  logic [NWAYS-1:0] wayValid, wayDirty, wayHit;
  logic [TAG_W-1:0]  wayTag  [NWAYS];
  logic [LINE_W-1:0] wayLine [NWAYS];
  logic              hitWay;
  logic              chosenWay;
  logic              victimWay;
  logic [TAG_W-1:0]  victimTag;
  logic [SETS-1:0]   lruBits;

  assign hitWay = wayHit[1];
  assign hit    = |wayHit;

  genvar w;
  generate
    for (w = 0; w < NWAYS; w++) begin : gWay
      logic [SETS-1:0]   validBits;
      logic [SETS-1:0]   dirtyBits;
      logic [TAG_W-1:0]  tagMem  [SETS];
      logic [LINE_W-1:0] dataMem [SETS];
      logic              fillHere;
      logic              storeHere;

      assign fillHere  = strobes.fill && (victimWay == 1'(w));
      assign storeHere = strobes.hitUpdate && reqWrite && (hitWay == 1'(w));

      always_ff @(posedge clk) begin
        if (rst) begin
          validBits <= '0;
          dirtyBits <= '0;
        end else if (fillHere) begin
          validBits[reqSet] <= 1'b1;
          dirtyBits[reqSet] <= 1'b0;
        end else if (storeHere) begin
          dirtyBits[reqSet] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (fillHere) begin
          tagMem[reqSet]  <= reqTag;
          dataMem[reqSet] <= memRdData;
        end else if (storeHere) begin
          dataMem[reqSet][{reqOff, 3'b000} +: 8] <= reqWdata;
        end
      end

      assign wayValid[w] = validBits[reqSet];
      assign wayDirty[w] = dirtyBits[reqSet];
      assign wayTag[w]   = tagMem[reqSet];
      assign wayLine[w]  = dataMem[reqSet];
      assign wayHit[w]   = validBits[reqSet] && (tagMem[reqSet] == reqTag);
    end
  endgenerate

  // Victim choice: empty way, then clean way, then least recently used.
  always_comb begin
    if (!wayValid[0])                chosenWay = 1'b0;
    else if (!wayValid[1])           chosenWay = 1'b1;
    else if (wayDirty[0] != wayDirty[1]) chosenWay = wayDirty[0];
    else                             chosenWay = lruBits[reqSet];
  end

  assign victimDirty = wayValid[chosenWay] && wayDirty[chosenWay];

  always_ff @(posedge clk) begin
    if (strobes.latchVictim) begin
      victimWay <= chosenWay;
      victimTag <= wayTag[chosenWay];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lruBits <= '0;
    end else if (strobes.hitUpdate) begin
      lruBits[reqSet] <= ~hitWay;
    end else if (strobes.fill) begin
      lruBits[reqSet] <= ~victimWay;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpuRespValid <= 1'b0;
      cpuRdata     <= '0;
    end else begin
      cpuRespValid <= strobes.hitUpdate;
      if (strobes.hitUpdate)
        cpuRdata <= reqWrite ? reqWdata : wayLine[hitWay][{reqOff, 3'b000} +: 8];
    end
  end

  assign memRdAddr = reqAddr[ADDR_W-1:OFF_W];
  assign memWrAddr = {victimTag, reqSet};
  assign memWrData = wayLine[victimWay];

endmodule

// File: rtl/wb2way_cache.sv
module wb2way_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 4,
  parameter int SET_W  = 7,
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int LINE_W  = 8 * (1 << OFF_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpuValid,
  output logic               cpuReady,
  input  logic               cpuWrite,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [7:0]         cpuWdata,
  output logic               cpuRespValid,
  output logic [7:0]         cpuRdata,
  output logic               memRdReq,
  output logic [LADDR_W-1:0] memRdAddr,
  input  logic               memRdAck,
  input  logic [LINE_W-1:0]  memRdData,
  output logic               memWrReq,
  output logic [LADDR_W-1:0] memWrAddr,
  output logic [LINE_W-1:0]  memWrData,
  input  logic               memWrAck
);

  ctrlStrobes_t strobes;
  logic hit, victimDirty;

  cache_ctrl uCtrl (
    .clk(clk), .rst(rst), .cpuValid(cpuValid), .hit(hit),
    .victimDirty(victimDirty), .memWrAck(memWrAck), .memRdAck(memRdAck),
    .strobes(strobes), .cpuReady(cpuReady), .memRdReq(memRdReq),
    .memWrReq(memWrReq)
  );

  cache_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .memRdData(memRdData),
    .hit(hit), .victimDirty(victimDirty), .cpuRespValid(cpuRespValid),
    .cpuRdata(cpuRdata), .memRdAddr(memRdAddr), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

endmodule

// File: rtl/wb2way_cache_checker.sv
module wb2way_cache_checker #(
  parameter int LADDR_W = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               cpuValid,
  input logic               cpuReady,
  input logic               cpuRespValid,
  input logic               memRdReq,
  input logic               memRdAck,
  input logic [LADDR_W-1:0] memRdAddr,
  input logic               memWrReq,
  input logic               memWrAck,
  input logic [LADDR_W-1:0] memWrAddr
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpuReady && !memRdReq && !memWrReq));

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (memRdReq && !memRdAck) |=> (memRdReq && $stable(memRdAddr)));

  assert_resp_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
    cpuRespValid |-> (!memRdReq && !memWrReq));

  assert_resp_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    cpuRespValid |=> !cpuRespValid);

  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (memWrReq && !memWrAck) |=> (memWrReq && $stable(memWrAddr)));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(memWrReq && memRdReq));

  assert_wb_then_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    (memWrReq && memWrAck) |=> memRdReq);

  assert_ready_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (cpuValid && cpuReady) |=> !cpuReady);

  assert_resp_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
    cpuRespValid |-> !$past(cpuReady));

endmodule

bind wb2way_cache wb2way_cache_checker #(.LADDR_W(LADDR_W)) uChk (
  .clk(clk), .rst(rst), .cpuValid(cpuValid), .cpuReady(cpuReady),
  .cpuRespValid(cpuRespValid), .memRdReq(memRdReq), .memRdAck(memRdAck),
  .memRdAddr(memRdAddr), .memWrReq(memWrReq), .memWrAck(memWrAck),
  .memWrAddr(memWrAddr)
);

// File: tb/wb2way_cache_test.sv
module wb2way_cache_test;

  logic         clk = 1'b0;
  logic         rst;
  logic         cpuValid, cpuReady, cpuWrite;
  logic [23:0]  cpuAddr;
  logic [7:0]   cpuWdata;
  logic         cpuRespValid;
  logic [7:0]   cpuRdata;
  logic         memRdReq, memRdAck;
  logic [19:0]  memRdAddr;
  logic [127:0] memRdData;
  logic         memWrReq, memWrAck;
  logic [19:0]  memWrAddr;
  logic [127:0] memWrData;

  always #2 clk = ~clk;

  wb2way_cache uut (
    .clk(clk), .rst(rst), .cpuValid(cpuValid), .cpuReady(cpuReady),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRespValid(cpuRespValid), .cpuRdata(cpuRdata),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdAck(memRdAck),
    .memRdData(memRdData), .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrAck(memWrAck)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cycle = 0;
  int rdCount = 0, wbCount = 0;
  int lastRdAddr = -1, lastWbAddr = -1;
  int lastRdCycle = 0, lastWbCycle = 0;
  int lastLat = 0;
  bit finished = 0;

  byte unsigned goldMem[int];
  byte unsigned backMem[int];
  byte unsigned expQ[$];
  string tagQ[$];

  always @(posedge clk) cycle <= cycle + 1;

  function automatic byte unsigned patt(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'(a >> 16) ^ 8'h5A;
  endfunction

  function automatic byte unsigned goldRead(int a);
    return goldMem.exists(a) ? goldMem[a] : patt(a);
  endfunction

  function automatic byte unsigned backRead(int a);
    return backMem.exists(a) ? backMem[a] : patt(a);
  endfunction

  function automatic logic [23:0] mk(int t, int s, int o);
    return {13'(t), 7'(s), 4'(o)};
  endfunction

  function automatic int lineOf(int t, int s);
    return (t << 7) | s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: pushes the expected result, then performs the handshake.
  task automatic access(bit wr, logic [23:0] a, byte unsigned d, string req);
    if (wr) begin
      expQ.push_back(d);
      goldMem[int'(a)] = d;
    end else begin
      expQ.push_back(goldRead(int'(a)));
    end
    tagQ.push_back(req);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    while (!cpuReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpuValid = 1'b0;
    check(cpuReady == 1'b0, "R10", "ready low after accept", int'(cpuReady), 0);
    lastLat = 1;
    while (!cpuRespValid) begin
      @(negedge clk);
      lastLat++;
    end
  endtask

  // Monitor: scoreboard comparison of completed accesses.
  always @(negedge clk) begin
    if (!rst && cpuRespValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "response with no pending access", int'(cpuRdata), -1);
      end else begin
        automatic byte unsigned e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(cpuRdata == e, t, "returned byte", int'(cpuRdata), int'(e));
      end
    end
  end

  // Memory responder.
  initial begin
    memRdAck = 1'b0; memWrAck = 1'b0; memRdData = '0;
    forever begin
      @(negedge clk);
      if (!rst && memWrReq) begin
        wbCount++;
        lastWbAddr = int'(memWrAddr);
        lastWbCycle = cycle;
        for (int i = 0; i < 16; i++) begin
          automatic int ba = (int'(memWrAddr) << 4) | i;
          check(memWrData[i*8 +: 8] == goldRead(ba), "R7", "write-back byte",
                int'(memWrData[i*8 +: 8]), int'(goldRead(ba)));
          backMem[ba] = memWrData[i*8 +: 8];
        end
        repeat (2) @(negedge clk);
        memWrAck = 1'b1;
        @(negedge clk);
        memWrAck = 1'b0;
      end else if (!rst && memRdReq) begin
        rdCount++;
        lastRdAddr = int'(memRdAddr);
        lastRdCycle = cycle;
        check(cpuReady == 1'b0, "R10", "ready low during fetch", int'(cpuReady), 0);
        for (int i = 0; i < 16; i++)
          memRdData[i*8 +: 8] = backRead((int'(memRdAddr) << 4) | i);
        repeat (2) @(negedge clk);
        memRdAck = 1'b1;
        @(negedge clk);
        memRdAck = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int r0, w0;
    logic [15:0] lfsr;
    rst = 1'b1; cpuValid = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; cpuWdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cpuReady == 1'b1, "R1", "ready after reset", int'(cpuReady), 1);
    check(!memRdReq && !memWrReq, "R1", "no memory request after reset",
          int'({memRdReq, memWrReq}), 0);

    // R1: address 0 is not resident after reset.
    access(0, mk(0, 0, 0), 0, "R1");
    check(rdCount == 1, "R1", "fetch count after first read", rdCount, 1);

    // R2: fetch carries addr[23:4].
    access(0, mk(1, 5, 3), 0, "R2");
    check(lastRdAddr == lineOf(1, 5), "R2", "fetch line address", lastRdAddr, lineOf(1, 5));

    // R3: read hit, two cycles, no fetch.
    r0 = rdCount;
    access(0, mk(1, 5, 9), 0, "R3");
    check(rdCount == r0, "R3", "fetches on hit", rdCount, r0);
    check(lastLat == 2, "R3", "hit latency", lastLat, 2);

    // R4: write hit stays in cache.
    access(1, mk(1, 5, 9), 8'hA5, "R4");
    check(rdCount == r0 && wbCount == 0, "R4", "memory traffic on write hit",
          rdCount + wbCount, r0);
    access(0, mk(1, 5, 9), 0, "R4");

    // R5: empty way taken, resident line kept.
    access(0, mk(2, 5, 0), 0, "R5");
    check(rdCount == r0 + 1 && wbCount == 0, "R5", "fetch without write-back",
          rdCount, r0 + 1);
    access(0, mk(1, 5, 9), 0, "R5");
    access(0, mk(2, 5, 0), 0, "R5");
    check(rdCount == r0 + 1, "R5", "both lines resident", rdCount, r0 + 1);

    // R6: dirty tag1 is LRU, clean tag2 still replaced.
    access(0, mk(3, 5, 1), 0, "R6");
    check(wbCount == 0, "R6", "write-backs when clean way exists", wbCount, 0);
    r0 = rdCount;
    access(0, mk(1, 5, 9), 0, "R6");
    check(rdCount == r0, "R6", "dirty line kept", rdCount, r0);

    // R7: both dirty, LRU (tag1) written back before the fetch.
    access(1, mk(3, 5, 1), 8'h77, "R7");
    access(0, mk(4, 5, 2), 0, "R7");
    check(wbCount == 1, "R7", "write-back count", wbCount, 1);
    check(lastWbAddr == lineOf(1, 5), "R7", "write-back line address", lastWbAddr, lineOf(1, 5));
    check(lastWbCycle < lastRdCycle, "R7", "write-back before fetch", lastWbCycle, lastRdCycle);
    check(backRead(int'(mk(1, 5, 9))) == 8'hA5, "R7", "memory holds stored byte",
          int'(backRead(int'(mk(1, 5, 9)))), 'hA5);
    r0 = rdCount;
    access(0, mk(3, 5, 1), 0, "R7");
    check(rdCount == r0, "R7", "other dirty way kept", rdCount, r0);

    // R8: both clean, LRU decided by a hit.
    access(0, mk(1, 9, 0), 0, "R8");
    access(0, mk(2, 9, 0), 0, "R8");
    access(0, mk(1, 9, 0), 0, "R8");
    access(0, mk(3, 9, 0), 0, "R8");
    r0 = rdCount;
    access(0, mk(1, 9, 0), 0, "R8");
    check(rdCount == r0, "R8", "recently used line kept", rdCount, r0);
    access(0, mk(2, 9, 0), 0, "R8");
    check(rdCount == r0 + 1, "R8", "LRU line evicted", rdCount, r0 + 1);
    check(wbCount == 1, "R8", "no write-back of clean lines", wbCount, 1);

    // R9: write miss allocates and dirties.
    w0 = rdCount;
    access(1, mk(7, 20, 2), 8'h3C, "R9");
    check(rdCount == w0 + 1, "R9", "fetch on write miss", rdCount, w0 + 1);
    access(0, mk(7, 20, 2), 0, "R9");
    access(0, mk(7, 20, 5), 0, "R9");
    check(rdCount == w0 + 1, "R9", "line resident after write miss", rdCount, w0 + 1);
    access(1, mk(8, 20, 0), 8'h11, "R9");
    access(0, mk(9, 20, 0), 0, "R9");
    check(wbCount == 2, "R9", "merged line written back", wbCount, 2);
    check(lastWbAddr == lineOf(7, 20), "R9", "write-back address", lastWbAddr, lineOf(7, 20));
    check(backRead(int'(mk(7, 20, 2))) == 8'h3C, "R9", "merged byte in memory",
          int'(backRead(int'(mk(7, 20, 2)))), 'h3C);

    // Mixed traffic on two sets, scoreboard checked.
    lfsr = 16'hACE1;
    for (int k = 0; k < 80; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[9] & lfsr[8], mk(int'(lfsr[2:0]), 3 + int'(lfsr[3]), int'(lfsr[7:4])),
             lfsr[15:8], "R3");
    end

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3", "pending responses", expQ.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule